// File: doc/BRIEF.md
# Indexed Colour Palette with Auto-Increment Port

This block is a 256-entry colour lookup table. Each entry holds a red, green and blue component of 6 bits each. Software reaches the table through a byte-wide register port with four registers: a pixel mask, a read pointer, a write pointer and a data window. Writing a pointer selects an entry. Successive data accesses then move through red, green and blue. After the blue byte, the pointer steps to the next entry, and from 255 it wraps to 0. A long run of triplets can therefore be streamed after a single pointer write.

On the video side, an 8-bit pixel code is ANDed with the mask register. The result selects an entry, and the entry's three components appear on the colour outputs one clock later. A mask of zero sends every pixel to entry 0, which blanks the picture to one colour. The table can be reloaded while the video path keeps reading it.

Top module: `color_lut`

## Requirements
- R1: After reset the mask register reads 0xFF, both pointers read 0, both component positions are at red, and every entry holds zero.
- R2: Register select codes are 0 for mask, 1 for read pointer, 2 for write pointer and 3 for data. After the write pointer is set, three data writes supply red, green and blue of that entry in that order. The pointer then advances by one.
- R3: An entry keeps its old contents until the blue byte of its triplet has been written.
- R4: Writing the write pointer puts the write sequence back at red and discards a partial triplet.
- R5: After the read pointer is set, three data reads return red, green and blue of that entry in the low 6 bits, with the top 2 bits zero. The read pointer then advances by one.
- R6: Writing the read pointer puts the read sequence back at red.
- R7: Both pointers wrap from 255 to 0 when they advance.
- R8: Only the low 6 bits of a written data byte are stored. The top 2 bits are ignored.
- R9: The pixel code is ANDed bit by bit with the mask before the lookup.
- R10: A mask of 0 makes every pixel code look up entry 0.
- R11: The colour outputs reflect the pixel code of the previous clock. A table write in that same clock to the looked-up entry still shows the old colour.
- R12: Reading select codes 0, 1 and 2 returns the current mask, read pointer and write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Register select (0 mask, 1 read pointer, 2 write pointer, 3 data) |
| bus_wr | input | 1 | Write strobe, one access per clock |
| bus_rd | input | 1 | Read strobe, ignored when bus_wr is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, valid in the strobe cycle |
| pix_idx | input | 8 | Pixel code from the video pipeline |
| vid_red | output | 6 | Red component of the looked-up entry |
| vid_green | output | 6 | Green component of the looked-up entry |
| vid_blue | output | 6 | Blue component of the looked-up entry |

## Verification
A wrong component position shows up within one triplet. Colours land in the wrong channel, or the next entry gets the tail of the previous triplet, and the first video lookup of that entry exposes it. A pointer that fails to advance or wrap is visible directly through the pointer readback. It also shows through the entry that the following triplet lands in. A wrong mask gate or lookup latency shows on the colour outputs exactly one clock after the pixel code is presented.

// File: rtl/color_lut_pkg.sv
package color_lut_pkg;
   typedef enum logic [1:0] {
      PH_RED = 2'd0,
      PH_GRN = 2'd1,
      PH_BLU = 2'd2
   } phase_t;

   localparam logic [1:0] SEL_MASK = 2'd0;
   localparam logic [1:0] SEL_RPTR = 2'd1;
   localparam logic [1:0] SEL_WPTR = 2'd2;
   localparam logic [1:0] SEL_DATA = 2'd3;

   localparam int NUM_CHAN = 3;
endpackage

// File: rtl/color_lut_seq.sv
module color_lut_seq
   import color_lut_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [IDX_W-1:0] load_val,
   input  logic             step,
   output logic [IDX_W-1:0] idx,
   output phase_t           phase,
   output logic             last
);
   assign last = step && !load && (phase == PH_BLU);

   always_ff @(posedge clk) begin
      if (rst) begin
         idx   <= '0;
         phase <= PH_RED;
      end else if (load) begin
         idx   <= load_val;
         phase <= PH_RED;
      end else if (step) begin
         unique case (phase)
            PH_RED:  phase <= PH_GRN;
            PH_GRN:  phase <= PH_BLU;
            default: begin
               phase <= PH_RED;
               idx   <= idx + 1'b1;
            end
         endcase
      end
   end
endmodule

// File: rtl/color_lut_store.sv
module color_lut_store
   import color_lut_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int COMP_W = 6
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         we,
   input  logic [IDX_W-1:0]             waddr,
   input  logic [NUM_CHAN*COMP_W-1:0]   wdata,
   input  logic [IDX_W-1:0]             raddr,
   output logic [NUM_CHAN*COMP_W-1:0]   rdata,
   input  logic [IDX_W-1:0]             vaddr,
   output logic [NUM_CHAN*COMP_W-1:0]   vdata
);
   localparam int DEPTH = 1 << IDX_W;

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      localparam int LSB = (NUM_CHAN - 1 - c) * COMP_W;
      logic [COMP_W-1:0] arr [DEPTH];

      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < DEPTH; i++) arr[i] <= '0;
         end else if (we) begin
            arr[waddr] <= wdata[LSB +: COMP_W];
         end
      end

      always_ff @(posedge clk) begin
         if (rst) vdata[LSB +: COMP_W] <= '0;
         else     vdata[LSB +: COMP_W] <= arr[vaddr];
      end

      assign rdata[LSB +: COMP_W] = arr[raddr];
   end
endmodule

// File: rtl/color_lut_pixmask.sv
module color_lut_pixmask #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [IDX_W-1:0] load_val,
   input  logic [IDX_W-1:0] pix_in,
   output logic [IDX_W-1:0] pix_out,
   output logic [IDX_W-1:0] mask
);
   always_ff @(posedge clk) begin
      if (rst)       mask <= '1;
      else if (load) mask <= load_val;
   end

   assign pix_out = pix_in & mask;
endmodule

// File: rtl/color_lut.sv
module color_lut
   import color_lut_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int COMP_W = 6,
   parameter int BUS_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [IDX_W-1:0]  pix_idx,
   output logic [COMP_W-1:0] vid_red,
   output logic [COMP_W-1:0] vid_green,
   output logic [COMP_W-1:0] vid_blue
);
   localparam int ENT_W = NUM_CHAN * COMP_W;

   if (BUS_W < COMP_W || BUS_W < IDX_W) begin : g_bad_width
      $error("color_lut: BUS_W must cover COMP_W and IDX_W");
   end

   logic              wr_load, wr_step, wr_last;
   logic              rd_load, rd_step, rd_last;
   logic [IDX_W-1:0]  wr_idx, rd_idx, mask, pix_masked;
   phase_t            wr_ph, rd_ph;
   logic [COMP_W-1:0] hold_r, hold_g;
   logic [ENT_W-1:0]  host_ent, vid_ent, commit_ent;
   logic [COMP_W-1:0] rd_comp;
   logic              mask_load, unused_rd_last;

   assign wr_load   = bus_wr && (bus_sel == SEL_WPTR);
   assign wr_step   = bus_wr && (bus_sel == SEL_DATA);
   assign rd_load   = bus_wr && (bus_sel == SEL_RPTR);
   assign rd_step   = bus_rd && !bus_wr && (bus_sel == SEL_DATA);
   assign mask_load = bus_wr && (bus_sel == SEL_MASK);
   assign unused_rd_last = rd_last;

   color_lut_seq #(.IDX_W(IDX_W)) u_wseq (
      .clk(clk), .rst(rst), .load(wr_load), .load_val(bus_wdata[IDX_W-1:0]),
      .step(wr_step), .idx(wr_idx), .phase(wr_ph), .last(wr_last)
   );

   color_lut_seq #(.IDX_W(IDX_W)) u_rseq (
      .clk(clk), .rst(rst), .load(rd_load), .load_val(bus_wdata[IDX_W-1:0]),
      .step(rd_step), .idx(rd_idx), .phase(rd_ph), .last(rd_last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_r <= '0;
         hold_g <= '0;
      end else if (wr_step) begin
         if (wr_ph == PH_RED) hold_r <= bus_wdata[COMP_W-1:0];
         if (wr_ph == PH_GRN) hold_g <= bus_wdata[COMP_W-1:0];
      end
   end

   assign commit_ent = {hold_r, hold_g, bus_wdata[COMP_W-1:0]};

   color_lut_pixmask #(.IDX_W(IDX_W)) u_mask (
      .clk(clk), .rst(rst), .load(mask_load), .load_val(bus_wdata[IDX_W-1:0]),
      .pix_in(pix_idx), .pix_out(pix_masked), .mask(mask)
   );

   color_lut_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
      .clk(clk), .rst(rst), .we(wr_last), .waddr(wr_idx), .wdata(commit_ent),
      .raddr(rd_idx), .rdata(host_ent), .vaddr(pix_masked), .vdata(vid_ent)
   );

   always_comb begin
      unique case (rd_ph)
         PH_RED:  rd_comp = host_ent[2*COMP_W +: COMP_W];
         PH_GRN:  rd_comp = host_ent[COMP_W +: COMP_W];
         default: rd_comp = host_ent[0 +: COMP_W];
      endcase
   end

   always_comb begin
      unique case (bus_sel)
         SEL_MASK: bus_rdata = BUS_W'(mask);
         SEL_RPTR: bus_rdata = BUS_W'(rd_idx);
         SEL_WPTR: bus_rdata = BUS_W'(wr_idx);
         default:  bus_rdata = BUS_W'(rd_comp);
      endcase
   end

   assign vid_red   = vid_ent[2*COMP_W +: COMP_W];
   assign vid_green = vid_ent[COMP_W +: COMP_W];
   assign vid_blue  = vid_ent[0 +: COMP_W];
endmodule

// File: rtl/color_lut_chk.sv
module color_lut_chk #(
   parameter int IDX_W  = 8,
   parameter int COMP_W = 6,
   parameter int BUS_W  = 8
) (
   input logic             clk,
   input logic             rst,
   input logic [1:0]       bus_sel,
   input logic             bus_wr,
   input logic             bus_rd,
   input logic [BUS_W-1:0] bus_rdata,
   input logic [IDX_W-1:0] wr_idx,
   input logic [IDX_W-1:0] rd_idx,
   input logic [1:0]       wr_ph,
   input logic [1:0]       rd_ph
);
   AST_WPTR_STEP: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_sel == 2'd3 && wr_ph == 2'd2) |=> (wr_idx == IDX_W'($past(wr_idx) + 1'b1))); // R7
   AST_RPTR_STEP: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && !bus_wr && bus_sel == 2'd3 && rd_ph == 2'd2) |=> (rd_idx == IDX_W'($past(rd_idx) + 1'b1))); // R5
   AST_WPTR_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(bus_wr && (bus_sel == 2'd2 || (bus_sel == 2'd3 && wr_ph == 2'd2))) |=> $stable(wr_idx)); // R2
   AST_WPH_RESTART: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_sel == 2'd2) |=> (wr_ph == 2'd0)); // R4
   AST_RPH_RESTART: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_sel == 2'd1) |=> (rd_ph == 2'd0)); // R6
   AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
      (wr_ph != 2'd3) && (rd_ph != 2'd3)); // R2
   AST_RDATA_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
      (bus_sel == 2'd3) |-> ((bus_rdata >> COMP_W) == '0)); // R5
endmodule

bind color_lut color_lut_chk #(.IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W)) u_chk (
   .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_rdata(bus_rdata), .wr_idx(wr_idx), .rd_idx(rd_idx),
   .wr_ph(wr_ph), .rd_ph(rd_ph)
);

// File: tb/color_lut_tb.sv
module color_lut_tb;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [17:0] val;
      string       tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] bus_sel = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic [7:0] pix_idx = '0;
   logic [5:0] vid_red, vid_green, vid_blue;
   logic       vchk = 1'b0, vchk_d = 1'b0;
   int         checks = 0, fails = 0;
   bit         done = 1'b0;
   exp_t       rd_q[$];
   exp_t       vd_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   color_lut u_dut (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_idx(pix_idx),
      .vid_red(vid_red), .vid_green(vid_green), .vid_blue(vid_blue)
   );

   function automatic logic [17:0] rgb(input logic [5:0] r, g, b);
      return {r, g, b};
   endfunction

   task automatic cyc(input logic wr, rd, input logic [1:0] sel, input logic [7:0] d,
                      input logic vc, input logic [7:0] px);
      @(posedge clk); #1;
      bus_wr = wr; bus_rd = rd; bus_sel = sel; bus_wdata = d;
      vchk = vc; pix_idx = px;
   endtask

   task automatic wreg(input logic [1:0] sel, input logic [7:0] d);
      cyc(1'b1, 1'b0, sel, d, 1'b0, 8'h00);
   endtask

   task automatic rreg(input logic [1:0] sel, input logic [7:0] exp, input string tag);
      exp_t e;
      e.val = {10'h0, exp}; e.tag = tag;
      rd_q.push_back(e);
      cyc(1'b0, 1'b1, sel, 8'h00, 1'b0, 8'h00);
   endtask

   task automatic vlook(input logic [7:0] px, input logic [17:0] exp, input string tag);
      exp_t e;
      e.val = exp; e.tag = tag;
      vd_q.push_back(e);
      cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, px);
   endtask

   task automatic idle();
      cyc(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00);
   endtask

   task automatic triplet(input logic [7:0] r, g, b);
      wreg(2'd3, r); wreg(2'd3, g); wreg(2'd3, b);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // monitor: compares design results against queued expectations
   always @(negedge clk) begin
      if (!rst) begin
         if (bus_rd && !bus_wr) begin
            exp_t e;
            if (rd_q.size() == 0) begin
               checks++; fails++;
               $display("FAIL bus read with empty queue actual=%h expected=none", bus_rdata);
            end else begin
               e = rd_q.pop_front();
               checks++;
               if (bus_rdata !== e.val[7:0]) begin
                  fails++;
                  $display("FAIL %s bus read actual=%h expected=%h", e.tag, bus_rdata, e.val[7:0]);
               end
            end
         end
         if (vchk_d) begin
            exp_t e;
            if (vd_q.size() == 0) begin
               checks++; fails++;
               $display("FAIL video check with empty queue actual=%h expected=none",
                        {vid_red, vid_green, vid_blue});
            end else begin
               e = vd_q.pop_front();
               checks++;
               if ({vid_red, vid_green, vid_blue} !== e.val) begin
                  fails++;
                  $display("FAIL %s video actual=%h expected=%h", e.tag,
                           {vid_red, vid_green, vid_blue}, e.val);
               end
            end
         end
         vchk_d = vchk;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      // R1 / R12: reset state through readback and video
      rreg(2'd0, 8'hFF, "R1");
      rreg(2'd1, 8'h00, "R1");
      rreg(2'd2, 8'h00, "R12");
      vlook(8'h33, rgb(6'h0, 6'h0, 6'h0), "R1");
      // R2: basic triplet load
      wreg(2'd2, 8'd5);
      triplet(8'h11, 8'h22, 8'h33);
      rreg(2'd2, 8'd6, "R2");
      vlook(8'd5, rgb(6'h11, 6'h22, 6'h33), "R2");
      // R8: top bits of written bytes dropped
      wreg(2'd2, 8'd7);
      triplet(8'hD5, 8'h6A, 8'hFF);
      vlook(8'd7, rgb(6'h15, 6'h2A, 6'h3F), "R8");
      // R3: partial triplet not visible
      wreg(2'd2, 8'd9);
      wreg(2'd3, 8'h01); wreg(2'd3, 8'h02);
      vlook(8'd9, rgb(6'h0, 6'h0, 6'h0), "R3");
      wreg(2'd3, 8'h03);
      vlook(8'd9, rgb(6'h01, 6'h02, 6'h03), "R3");
      // R4: rewriting write pointer restarts at red
      wreg(2'd2, 8'd10);
      wreg(2'd3, 8'h2E);
      wreg(2'd2, 8'd10);
      triplet(8'h07, 8'h08, 8'h09);
      vlook(8'd10, rgb(6'h07, 6'h08, 6'h09), "R4");
      // R5: triplet readback and read pointer advance
      wreg(2'd1, 8'd5);
      rreg(2'd3, 8'h11, "R5");
      rreg(2'd3, 8'h22, "R5");
      rreg(2'd3, 8'h33, "R5");
      rreg(2'd1, 8'd6, "R5");
      rreg(2'd3, 8'h00, "R5");
      // R6: rewriting read pointer restarts at red
      wreg(2'd1, 8'd7);
      rreg(2'd3, 8'h15, "R6");
      wreg(2'd1, 8'd7);
      rreg(2'd3, 8'h15, "R6");
      rreg(2'd3, 8'h2A, "R6");
      rreg(2'd3, 8'h3F, "R6");
      // R7: wrap of both pointers
      wreg(2'd2, 8'd255);
      triplet(8'h01, 8'h02, 8'h03);
      triplet(8'h04, 8'h05, 8'h06);
      rreg(2'd2, 8'd1, "R7");
      vlook(8'd255, rgb(6'h01, 6'h02, 6'h03), "R7");
      vlook(8'd0, rgb(6'h04, 6'h05, 6'h06), "R7");
      wreg(2'd1, 8'd255);
      rreg(2'd3, 8'h01, "R7");
      rreg(2'd3, 8'h02, "R7");
      rreg(2'd3, 8'h03, "R7");
      rreg(2'd1, 8'd0, "R7");
      rreg(2'd3, 8'h04, "R7");
      // R9 / R12: mask gating and readback
      wreg(2'd0, 8'h0F);
      rreg(2'd0, 8'h0F, "R12");
      vlook(8'hF5, rgb(6'h11, 6'h22, 6'h33), "R9");
      wreg(2'd0, 8'h07);
      vlook(8'h0F, rgb(6'h15, 6'h2A, 6'h3F), "R9");
      // R10: zero mask blanks to entry 0
      wreg(2'd0, 8'h00);
      vlook(8'hAB, rgb(6'h04, 6'h05, 6'h06), "R10");
      vlook(8'hFF, rgb(6'h04, 6'h05, 6'h06), "R10");
      // R11: latency and same-cycle write returns old value
      wreg(2'd0, 8'hFF);
      wreg(2'd2, 8'd20);
      wreg(2'd3, 8'h0A); wreg(2'd3, 8'h0B);
      begin
         exp_t e;
         e.val = rgb(6'h0, 6'h0, 6'h0); e.tag = "R11";
         vd_q.push_back(e);
         cyc(1'b1, 1'b0, 2'd3, 8'h0C, 1'b1, 8'd20);
      end
      vlook(8'd20, rgb(6'h0A, 6'h0B, 6'h0C), "R11");
      vlook(8'd5, rgb(6'h11, 6'h22, 6'h33), "R11");
      idle();
      idle();
      idle();
      if (rd_q.size() != 0 || vd_q.size() != 0) begin
         checks++; fails++;
         $display("FAIL scoreboard leftovers actual=%0d expected=0", rd_q.size() + vd_q.size());
      end
      finish_run();
   end
endmodule